// File: doc/BRIEF.md
# Serial-video timing reference inserter

This block takes a stream of 10-bit 4:2:2 component words at the 27 MHz word rate. Each word comes with three flags: horizontal blanking, vertical blanking and field. It produces the multiplexed parallel stream that a serializer expects. Sync is carried inside the data as four-word timing references, so no separate sync wires are needed.

A blanking run starts when the horizontal blanking flag rises. The first four words of that run are replaced by an end-of-active-video reference. The four words just before the first active word are replaced by a start-of-active-video reference. Every other blanking word becomes a blanking level. Active words are clipped so that they can never imitate a reference. On lines flagged as vertical blanking, the active region also carries blanking levels. The word clock goes out alongside the data so that the serializer can latch each word.

Both data sides use valid/ready. The block holds four words to look ahead for the start-of-active reference. It presents an output word only while those four words are held and a fifth word is being offered at the input, so `out_valid` follows `in_valid` and `in_ready` follows `out_ready` within the same cycle. The last four words of a stream stay inside the block until more input arrives. Words leave in the order they arrived.

Top module: `sdi_trs_inserter`

## Requirements
- R1: The first three words of each blanking run (the run starts where the horizontal blanking flag goes from 0 to 1) are 0x3FF, 0x000 and 0x000.
- R2: The fourth word of every reference is the flag word. Bit 9 is 1, bit 8 is F, bit 7 is V and bit 6 is H. Bits 5 to 2 hold the protection bits V^H, F^H, F^V and F^V^H, in that order. Bits 1:0 are 0. F and V are taken from the flags of the word the reference replaces.
- R3: H is 1 in the flag word of the end-of-active reference (blanking-run positions 0 to 3) and 0 in the start-of-active reference.
- R4: The four blanking words just before the first active word of a line are replaced, in order, by 0x3FF, 0x000, 0x000 and the flag word. When the two references compete for a position, the end-of-active reference wins.
- R5: Every other word whose horizontal blanking flag is 1 is output as a blanking level, and so is every word flagged as vertical blanking. The level depends on the word's position in its run, counted from 0: 0x200 at positions 0 and 2 (mod 4), and 0x040 at positions 1 and 3 (mod 4). The input data of these words has no effect.
- R6: Active words (both blanking flags 0) pass through clipped to the range 0x004 to 0x3FB. Values below 0x004 become 0x004, values above 0x3FB become 0x3FB, and all other values are unchanged.
- R7: `in_ready` is 1 while fewer than four words are held or `out_ready` is 1. `out_valid` is 1 exactly when four words are held and `in_valid` is 1. Words leave in arrival order.
- R8: During and right after reset no words are held, `out_valid` is 0 and `in_ready` is 1.
- R9: `out_clk` carries the word clock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted when valid is also 1 |
| in_data | input | 10 | Component sample |
| in_field | input | 1 | Field flag of the word |
| in_vblank | input | 1 | Vertical blanking flag of the word |
| in_hblank | input | 1 | Horizontal blanking flag of the word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 10 | Multiplexed word with references |
| out_clk | output | 1 | Word clock forwarded for latching |

## Verification
The bench builds the block with its default 10-bit word width, so the header values, blanking levels and clip limits are the ones listed above. Blanking runs of 8, 9, 12 and 16 words are used. The 8-word runs place the start-of-active reference directly after the end-of-active one, so the lookahead sees the active word at every offset. Line flags cover all four F/V combinations in both references. Random gaps on `in_valid` and `out_ready` exercise stalls while the pipe is full and while it is still filling.

// File: rtl/sdi_trs_pkg.sv
package sdi_trs_pkg;
  localparam int WORD_W  = 10;
  localparam int HDR_LEN = 4;
  localparam int PH_W    = $clog2(HDR_LEN);

  localparam logic [WORD_W-1:0] HDR_ONES = '1;
  localparam logic [WORD_W-1:0] HDR_ZERO = '0;
  localparam logic [WORD_W-1:0] C_BLANK  = WORD_W'(1) << (WORD_W - 1);
  localparam logic [WORD_W-1:0] Y_BLANK  = WORD_W'(1) << (WORD_W - 4);
  localparam logic [WORD_W-1:0] CLIP_LO  = WORD_W'(4);
  localparam logic [WORD_W-1:0] CLIP_HI  = HDR_ONES - WORD_W'(4);

  typedef struct packed {
    logic              fld;
    logic              vb;
    logic              hb;
    logic [WORD_W-1:0] dat;
  } samp_t;

  typedef enum logic [1:0] {
    SEL_ACTIVE = 2'd0,
    SEL_BLANK  = 2'd1,
    SEL_TRS    = 2'd2
  } word_sel_e;

  function automatic logic [WORD_W-1:0] flag_word(input logic f, input logic v, input logic h);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1] = 1'b1;
    w[WORD_W-2] = f;
    w[WORD_W-3] = v;
    w[WORD_W-4] = h;
    w[WORD_W-5] = v ^ h;
    w[WORD_W-6] = f ^ h;
    w[WORD_W-7] = f ^ v;
    w[WORD_W-8] = f ^ v ^ h;
    return w;
  endfunction
endpackage

// File: rtl/trs_lookahead.sv
module trs_lookahead
  import sdi_trs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  samp_t              in_samp,
  input  logic               out_ready,
  output logic               in_ready,
  output logic               out_valid,
  output logic               advance,
  output logic               full,
  output samp_t              cur,
  output logic [HDR_LEN:1]   ahead_h
);
  localparam int CNT_W = $clog2(HDR_LEN + 1);

  samp_t            st [HDR_LEN];
  logic [CNT_W-1:0] cnt;

  assign full      = (cnt == CNT_W'(HDR_LEN));
  assign in_ready  = !full || out_ready;
  assign out_valid = full && in_valid;
  assign advance   = in_valid && in_ready;
  assign cur       = st[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (advance && !full) cnt <= cnt + CNT_W'(1);
  end

  genvar gi;
  generate
    for (gi = 0; gi < HDR_LEN; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[gi] <= '0;
        else if (advance) begin
          if (gi == HDR_LEN - 1) st[gi] <= in_samp;
          else                   st[gi] <= st[(gi + 1) % HDR_LEN];
        end
      end
      if (gi > 0) begin : g_ahead
        assign ahead_h[gi] = st[gi].hb;
      end
    end
  endgenerate
  assign ahead_h[HDR_LEN] = in_samp.hb;

  // R7: the held-word count never exceeds the lookahead depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(HDR_LEN));
  // R8: after reset nothing is presented until words arrive
  a_r8_empty_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !out_valid);
endmodule

// File: rtl/trs_phase_track.sv
module trs_phase_track
  import sdi_trs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            full,
  input  logic            cur_h,
  input  logic            next_h,
  output logic [PH_W-1:0] phase,
  output logic            lead
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      lead  <= 1'b1;
    end else if (advance) begin
      if (full && (cur_h == next_h)) begin
        phase <= phase + PH_W'(1);
        if (phase == PH_W'(HDR_LEN - 1)) lead <= 1'b0;
      end else begin
        phase <= '0;
        lead  <= 1'b1;
      end
    end
  end

  // R1: a run always starts at phase zero with the lead window open
  a_r1_run_start: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && full && (cur_h != next_h)) |=> (lead && phase == '0));
endmodule

// File: rtl/trs_word_mux.sv
module trs_word_mux
  import sdi_trs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_valid,
  input  samp_t             cur,
  input  logic [HDR_LEN:1]  ahead_h,
  input  logic [PH_W-1:0]   phase,
  input  logic              lead,
  output logic [WORD_W-1:0] data,
  output word_sel_e         sel,
  output logic [PH_W-1:0]   hdr_idx,
  output logic              is_eav
);
  logic found;

  always_comb begin
    sel     = SEL_ACTIVE;
    hdr_idx = '0;
    is_eav  = 1'b0;
    found   = 1'b0;
    if (cur.hb) begin
      if (lead) begin
        sel     = SEL_TRS;
        hdr_idx = phase;
        is_eav  = 1'b1;
      end else begin
        for (int d = 1; d <= HDR_LEN; d++) begin
          if (!found && !ahead_h[d]) begin
            found   = 1'b1;
            hdr_idx = PH_W'(HDR_LEN - d);
          end
        end
        sel = found ? SEL_TRS : SEL_BLANK;
      end
    end else if (cur.vb) begin
      sel = SEL_BLANK;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_TRS: begin
        if (hdr_idx == '0)                     data = HDR_ONES;
        else if (hdr_idx == PH_W'(HDR_LEN-1))  data = flag_word(cur.fld, cur.vb, is_eav);
        else                                   data = HDR_ZERO;
      end
      SEL_BLANK: data = phase[0] ? Y_BLANK : C_BLANK;
      default: begin
        if (cur.dat < CLIP_LO)      data = CLIP_LO;
        else if (cur.dat > CLIP_HI) data = CLIP_HI;
        else                        data = cur.dat;
      end
    endcase
  end

  // R6: active words stay clear of the reserved code values
  a_r6_clip_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel == SEL_ACTIVE) |-> (data >= CLIP_LO && data <= CLIP_HI));
  // R4: a start-of-active flag word is followed directly by an active word
  a_r4_sav_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel == SEL_TRS && !is_eav && hdr_idx == PH_W'(HDR_LEN-1)) |-> !ahead_h[1]);
  // R5: blanking words carry one of the two blanking levels
  a_r5_blank_level: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel == SEL_BLANK) |-> (data == C_BLANK || data == Y_BLANK));
  // R2: flag words carry the marker bit and clear low bits
  a_r2_flag_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel == SEL_TRS && hdr_idx == PH_W'(HDR_LEN-1)) |-> (data[WORD_W-1] && data[1:0] == 2'b00));
endmodule

// File: rtl/sdi_trs_inserter.sv
module sdi_trs_inserter
  import sdi_trs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_field,
  input  logic              in_vblank,
  input  logic              in_hblank,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_clk
);
  samp_t            in_samp;
  samp_t            cur;
  logic [HDR_LEN:1] ahead_h;
  logic             advance;
  logic             full;
  logic [PH_W-1:0]  phase;
  logic             lead;
  word_sel_e        sel;
  logic [PH_W-1:0]  hdr_idx;
  logic             is_eav;

  assign in_samp = '{fld: in_field, vb: in_vblank, hb: in_hblank, dat: in_data};
  assign out_clk = clk;

  trs_lookahead u_look (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samp(in_samp),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .advance(advance), .full(full), .cur(cur), .ahead_h(ahead_h)
  );

  trs_phase_track u_phase (
    .clk(clk), .rst_n(rst_n), .advance(advance), .full(full),
    .cur_h(cur.hb), .next_h(ahead_h[1]), .phase(phase), .lead(lead)
  );

  trs_word_mux u_mux (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .cur(cur),
    .ahead_h(ahead_h), .phase(phase), .lead(lead), .data(out_data),
    .sel(sel), .hdr_idx(hdr_idx), .is_eav(is_eav)
  );

  // R3: end-of-active references only occupy the lead window of a blanking run
  a_r3_eav_window: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel == SEL_TRS && is_eav) |-> (cur.hb && lead));
endmodule

// File: tb/sdi_trs_inserter_tb_top.sv
module sdi_trs_inserter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       in_valid = 1'b0, in_field = 1'b0, in_vblank = 1'b0, in_hblank = 1'b0;
  logic [9:0] in_data = '0;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid, out_clk;
  logic [9:0] out_data;

  sdi_trs_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_field(in_field), .in_vblank(in_vblank),
    .in_hblank(in_hblank), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_clk(out_clk)
  );

  typedef struct {
    logic [9:0] d;
    logic f, v, h;
    int   idx;
  } word_t;

  word_t stim[$];
  word_t mq[$];
  int    checks = 0;
  int    fails  = 0;
  int    last_idx = -1;
  logic  last_h = 1'b0;
  bit    done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] act_val(input int k);
    case (k % 9)
      0: return 10'h3FF;
      1: return 10'h000;
      2: return 10'h001;
      3: return 10'h003;
      4: return 10'h004;
      5: return 10'h3FB;
      6: return 10'h3FC;
      7: return 10'h2A5;
      default: return 10'(k * 29 + 17);
    endcase
  endfunction

  function automatic logic [9:0] fw(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  task automatic build_stim();
    word_t w;
    for (int ln = 0; ln < 14; ln++) begin
      int hlen, alen;
      logic f, v;
      hlen = (ln % 4 == 0) ? 8 : (ln % 4 == 1) ? 9 : (ln % 4 == 2) ? 12 : 16;
      alen = 8 + (ln * 5) % 13;
      v = (ln < 3) || (ln == 7) || (ln == 8);
      f = (ln >= 7);
      for (int k = 0; k < hlen; k++) begin
        w.d = 10'($urandom); w.f = f; w.v = v; w.h = 1'b1; w.idx = 0;
        stim.push_back(w);
      end
      for (int k = 0; k < alen; k++) begin
        w.d = v ? 10'h3FF : act_val(k + ln); w.f = f; w.v = v; w.h = 1'b0; w.idx = 0;
        stim.push_back(w);
      end
    end
    w.d = 10'h111; w.f = 1'b1; w.v = 1'b0; w.h = 1'b1; w.idx = 0;
    for (int k = 0; k < 8; k++) stim.push_back(w);
  endtask

  // reference: expected word for model head given current input flag
  task automatic expect_word(output logic [9:0] e, output string tag);
    word_t c;
    int    fd;
    c  = mq[0];
    fd = 0;
    if (c.h) begin
      if (c.idx < 4) begin
        case (c.idx)
          0: begin e = 10'h3FF; tag = "R1"; end
          1, 2: begin e = 10'h000; tag = "R1"; end
          default: begin e = fw(c.f, c.v, 1'b1); tag = "R2/R3 eav"; end
        endcase
        return;
      end
      for (int d = 1; d <= 4; d++) begin
        logic hh;
        hh = (d < 4) ? mq[d].h : in_hblank;
        if (fd == 0 && !hh) fd = d;
      end
      if (fd != 0) begin
        case (4 - fd)
          0: e = 10'h3FF;
          1, 2: e = 10'h000;
          default: e = fw(c.f, c.v, 1'b0);
        endcase
        tag = (fd == 1) ? "R4/R2/R3 sav" : "R4";
        return;
      end
      e = (c.idx % 2 == 1) ? 10'h040 : 10'h200; tag = "R5";
    end else if (c.v) begin
      e = (c.idx % 2 == 1) ? 10'h040 : 10'h200; tag = "R5 vblank";
    end else begin
      e = (c.d < 10'h004) ? 10'h004 : (c.d > 10'h3FB) ? 10'h3FB : c.d;
      tag = "R6";
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [9:0] e;
    string tag;
    bit hs_in, hs_out;
    build_stim();
    in_valid = 1'b1;
    in_hblank = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
      chk(in_ready == 1'b1, "R8 in_ready in reset", in_ready, 1);
    end
    in_valid = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R8 after reset", {in_ready, out_valid}, 2'b10);

    for (int cyc = 0; stim.size() > 0; cyc++) begin
      @(posedge clk); #1;
      in_valid  = ($urandom % 5) != 0;
      out_ready = (cyc > 30 && cyc < 60) ? 1'b0 : (($urandom % 4) != 0);
      in_data   = stim[0].d;
      in_field  = stim[0].f;
      in_vblank = stim[0].v;
      in_hblank = stim[0].h;
      @(negedge clk);
      chk(in_ready == (mq.size() < 4 || out_ready), "R7 in_ready", in_ready, (mq.size() < 4 || out_ready));
      chk(out_valid == (mq.size() >= 4 && in_valid), "R7 out_valid", out_valid, (mq.size() >= 4 && in_valid));
      chk(out_clk == clk, "R9 out_clk", out_clk, clk);
      if (out_valid && mq.size() >= 4) begin
        expect_word(e, tag);
        chk(out_data == e, tag, out_data, e);
      end
      hs_in  = in_valid && in_ready;
      hs_out = out_valid && out_ready;
      if (hs_out && mq.size() > 0) void'(mq.pop_front());
      if (hs_in) begin
        word_t w;
        w = stim.pop_front();
        w.idx = (last_idx >= 0 && w.h == last_h) ? last_idx + 1 : 0;
        last_idx = w.idx;
        last_h = w.h;
        mq.push_back(w);
      end
    end
    done = 1;
    summary();
    $finish;
  end
endmodule